// File: doc/BRIEF.md
# Variable-Width Join Key Fetcher

This block walks a relation stored in memory and fetches one join key per tuple. After a start pulse it latches a base address, a tuple count, a tuple size in bytes, a key offset in bytes and a key length of 1 to 8 bytes. It then treats each tuple as a thread. For each thread it issues 64-bit word reads to a memory port that answers in order. When the key sits inside one word, one read is enough. When the key crosses a word boundary, two reads go out on consecutive word addresses, and the two answers are joined into one key.

Every issued thread leaves an entry in a small pending queue. The entry holds the tuple pointer, the starting byte lane, the key length and a flag for a two-word key. The response side pops these entries to pair the answers with their tuples. When the queue is full, no new thread issues. This holds the number of tuples awaiting data at the queue depth. Each finished key leaves on an output stream, together with the byte address of its tuple. Hashing and table updates belong to the blocks downstream.

Top module: `kf_key_fetch`

## Requirements
- R1: While reset is asserted and in the cycles after its release, `mem_req_valid`, `key_valid` and `busy` are low.
- R2: A start pulse while idle latches the configuration and raises `busy`. `busy` stays high until the final read request of the last tuple is accepted. A start with a tuple count of zero issues no requests and leaves `busy` low.
- R3: Tuple i has pointer `cfg_base + i*cfg_tuple_bytes`. Its key starts at byte address pointer + `cfg_key_off`. Requests carry word addresses, which are the byte address shifted right by 3. Tuples are requested in index order.
- R4: When the starting byte lane (byte address bits [2:0]) plus the key length is at most 8, the tuple costs exactly one read request.
- R5: When lane plus length exceeds 8, the tuple costs two requests, to word W and then W+1. The key is assembled from both responses.
- R6: Memory is little-endian: the byte at address A lies in bits [8*(A%8)+7 : 8*(A%8)] of its word. Key byte k (the byte at start address + k) lies in `key_data` bits [8k+7:8k]. Bytes at and above the key length are zero.
- R7: A request held while `mem_req_ready` is low keeps `mem_req_valid` high and keeps its address unchanged.
- R8: At most DEPTH tuples are awaiting responses. With responses withheld, exactly DEPTH first requests issue.
- R9: A start pulse while `busy` is high is ignored. The run in progress completes with its original configuration.
- R10: Keys leave in tuple order. `key_valid` is high for one cycle, in the cycle after the final response of that tuple.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with the current configuration |
| cfg_base | input | 32 | Byte address of tuple 0 |
| cfg_count | input | CW | Number of tuples |
| cfg_tuple_bytes | input | SW | Tuple size in bytes |
| cfg_key_off | input | SW | Key byte offset inside a tuple |
| cfg_key_len | input | 4 | Key length in bytes, 1 to 8 |
| busy | output | 1 | Requests remain to be issued |
| mem_req_valid | output | 1 | Read request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 29 | Word address of the read |
| mem_rsp_valid | input | 1 | In-order read data present |
| mem_rsp_data | input | 64 | Read data |
| key_valid | output | 1 | Key output valid |
| key_data | output | 64 | Zero-filled key |
| key_ptr | output | 32 | Byte address of the key's tuple |

## Verification
The bench targets keys that start in byte lane 7, keys of full 8-byte length at non-zero lanes, and tuple sizes that move the lane on every tuple. A design that got the boundary test wrong would drop a request or add one, which would leave every later key paired with the wrong data. A design that swapped the halves of a merge, or shifted by the wrong lane, would return bytes in the wrong order. Sparse ready and withheld responses check that a stalled address holds and that issue stops at the queue depth. Without that stop, entries would overflow and keys would lose their pointers. A start pulse in the middle of a run checks that a design which re-latched its configuration would not corrupt the remaining keys.

// File: rtl/kf_pkg.sv
package kf_pkg;
  parameter int KF_AW = 32;
  localparam int KF_WA = KF_AW - 3;

  typedef logic [2:0] lane_t;
  typedef logic [3:0] klen_t;

  typedef struct packed {
    logic [KF_AW-1:0] ptr;
    lane_t            lane;
    klen_t            len;
    logic             split;
  } pend_t;

  function automatic logic [63:0] keep_mask(klen_t n);
    logic [63:0] m;
    for (int b = 0; b < 8; b++) m[8*b +: 8] = (4'(b) < n) ? 8'hFF : 8'h00;
    return m;
  endfunction
endpackage

// File: rtl/kf_issue.sv
module kf_issue
  import kf_pkg::*;
#(
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KF_AW-1:0] cfg_base,
  input  logic [CW-1:0]    cfg_count,
  input  logic [SW-1:0]    cfg_tuple_bytes,
  input  logic [SW-1:0]    cfg_key_off,
  input  klen_t            cfg_key_len,
  input  logic             fifo_full,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [KF_WA-1:0] req_word,
  output logic             push,
  output pend_t            push_ent,
  output logic             busy
);
  logic             active_q, active_d;
  logic [CW-1:0]    idx_q, idx_d, cnt_q, cnt_d;
  logic [KF_AW-1:0] ptr_q, ptr_d;
  logic [SW-1:0]    off_q, off_d, size_q, size_d;
  klen_t            len_q, len_d;
  logic             sec_q, sec_d;
  logic [KF_WA-1:0] secw_q, secw_d;

  logic [KF_AW-1:0] key_addr;
  lane_t            lane;
  logic [KF_WA-1:0] word;
  logic             straddle, last_beat;

  always_comb begin
    key_addr = ptr_q + KF_AW'(off_q);
    lane     = key_addr[2:0];
    word     = key_addr[KF_AW-1:3];
    straddle = (4'(lane) + len_q) > 4'd8;

    active_d = active_q; idx_d = idx_q; cnt_d = cnt_q; ptr_d = ptr_q;
    off_d = off_q; size_d = size_q; len_d = len_q;
    sec_d = sec_q; secw_d = secw_q;
    req_valid = 1'b0; req_word = word; push = 1'b0; last_beat = 1'b0;

    if (!active_q) begin
      if (start && cfg_count != '0) begin
        active_d = 1'b1; idx_d = '0; cnt_d = cfg_count; ptr_d = cfg_base;
        off_d = cfg_key_off; size_d = cfg_tuple_bytes; len_d = cfg_key_len;
      end
    end else if (sec_q) begin
      req_valid = 1'b1;
      req_word  = secw_q;
      if (req_ready) begin
        sec_d     = 1'b0;
        last_beat = 1'b1;
      end
    end else if (!fifo_full) begin
      req_valid = 1'b1;
      if (req_ready) begin
        push = 1'b1;
        if (straddle) begin
          sec_d  = 1'b1;
          secw_d = word + KF_WA'(1);
        end else begin
          last_beat = 1'b1;
        end
      end
    end

    if (last_beat) begin
      idx_d = idx_q + CW'(1);
      ptr_d = ptr_q + KF_AW'(size_q);
      if (idx_q == cnt_q - CW'(1)) active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0; idx_q <= '0; cnt_q <= '0; ptr_q <= '0;
      off_q <= '0; size_q <= '0; len_q <= '0; sec_q <= 1'b0; secw_q <= '0;
    end else begin
      active_q <= active_d; idx_q <= idx_d; cnt_q <= cnt_d; ptr_q <= ptr_d;
      off_q <= off_d; size_q <= size_d; len_q <= len_d; sec_q <= sec_d; secw_q <= secw_d;
    end
  end

  assign push_ent = '{ptr: ptr_q, lane: lane, len: len_q, split: straddle};
  assign busy     = active_q;
endmodule

// File: rtl/kf_pend_fifo.sv
module kf_pend_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0] store [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [PW:0]   cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == PW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == PW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wp_q] <= din;
  end

  assign dout = store[rp_q];
  assign full = (cnt_q == (PW+1)'(DEPTH));
endmodule

// File: rtl/kf_merge.sv
module kf_merge
  import kf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsp_valid,
  input  logic [63:0]      rsp_data,
  input  pend_t            head,
  output logic             pop,
  output logic             key_valid,
  output logic [63:0]      key_data,
  output logic [KF_AW-1:0] key_ptr
);
  logic             phase_q, phase_d;
  logic [63:0]      hold_q, hold_d;
  logic             kv_q, kv_d;
  logic [63:0]      kd_q, kd_d;
  logic [KF_AW-1:0] kp_q, kp_d;
  logic [127:0]     pair, shifted;
  logic             first_half;

  always_comb begin
    pair       = head.split ? {rsp_data, hold_q} : {64'd0, rsp_data};
    shifted    = pair >> {head.lane, 3'b000};
    first_half = rsp_valid && head.split && !phase_q;
    pop        = rsp_valid && !first_half;

    phase_d = phase_q;
    if (first_half) phase_d = 1'b1;
    else if (pop)   phase_d = 1'b0;
    hold_d = first_half ? rsp_data : hold_q;
    kv_d   = pop;
    kd_d   = pop ? (shifted[63:0] & keep_mask(head.len)) : kd_q;
    kp_d   = pop ? head.ptr : kp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0; hold_q <= '0; kv_q <= 1'b0; kd_q <= '0; kp_q <= '0;
    end else begin
      phase_q <= phase_d; hold_q <= hold_d; kv_q <= kv_d; kd_q <= kd_d; kp_q <= kp_d;
    end
  end

  assign key_valid = kv_q;
  assign key_data  = kd_q;
  assign key_ptr   = kp_q;
endmodule

// File: rtl/kf_key_fetch.sv
module kf_key_fetch
  import kf_pkg::*;
#(
  parameter int CW    = 16,
  parameter int SW    = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KF_AW-1:0] cfg_base,
  input  logic [CW-1:0]    cfg_count,
  input  logic [SW-1:0]    cfg_tuple_bytes,
  input  logic [SW-1:0]    cfg_key_off,
  input  logic [3:0]       cfg_key_len,
  output logic             busy,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [KF_WA-1:0] mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             key_valid,
  output logic [63:0]      key_data,
  output logic [KF_AW-1:0] key_ptr
);
  localparam int PEW = $bits(pend_t);

  logic [1:0] rs_q;
  logic       rst_i;
  logic       fifo_push, fifo_pop, fifo_full;
  pend_t      push_ent, head;
  logic [PEW-1:0] head_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  kf_issue #(.CW(CW), .SW(SW)) u_issue (
    .clk(clk), .rst_n(rst_i), .start(start),
    .cfg_base(cfg_base), .cfg_count(cfg_count), .cfg_tuple_bytes(cfg_tuple_bytes),
    .cfg_key_off(cfg_key_off), .cfg_key_len(cfg_key_len),
    .fifo_full(fifo_full), .req_valid(mem_req_valid), .req_ready(mem_req_ready),
    .req_word(mem_req_addr), .push(fifo_push), .push_ent(push_ent), .busy(busy)
  );

  kf_pend_fifo #(.W(PEW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_i), .push(fifo_push), .din(push_ent),
    .pop(fifo_pop), .dout(head_bits), .full(fifo_full)
  );
  assign head = pend_t'(head_bits);

  kf_merge u_merge (
    .clk(clk), .rst_n(rst_i), .rsp_valid(mem_rsp_valid), .rsp_data(mem_rsp_data),
    .head(head), .pop(fifo_pop), .key_valid(key_valid), .key_data(key_data),
    .key_ptr(key_ptr)
  );
endmodule

// File: rtl/kf_checks.sv
module kf_checks
  import kf_pkg::*;
#(
  parameter int CW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic [CW-1:0]    cfg_count,
  input logic             req_valid,
  input logic             req_ready,
  input logic [KF_WA-1:0] req_word,
  input logic             push,
  input logic             full,
  input logic             pop,
  input logic [3:0]       head_len,
  input logic             rsp_valid,
  input logic             key_valid,
  input logic [63:0]      key_data
);
  logic [3:0] last_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   last_len_q <= 4'd8;
    else if (pop) last_len_q <= head_len;
  end

  p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_word));

  p_no_push_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  p_zero_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (key_data & ~keep_mask(last_len_q)) == 64'd0);

  p_key_after_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> $past(rsp_valid));

  p_empty_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && cfg_count == '0 |=> !busy);
endmodule

bind kf_key_fetch kf_checks #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_i), .start(start), .busy(busy), .cfg_count(cfg_count),
  .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_word(mem_req_addr),
  .push(fifo_push), .full(fifo_full), .pop(fifo_pop), .head_len(head.len),
  .rsp_valid(mem_rsp_valid), .key_valid(key_valid), .key_data(key_data)
);

// File: tb/tb_kf_key_fetch.sv
`timescale 1ns/1ps
module tb_kf_key_fetch;
  localparam int CW = 16, SW = 16, DEPTH = 8, LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_count = '0, cfg_tuple_bytes = '0, cfg_key_off = '0;
  logic [3:0]  cfg_key_len = 4'd1;
  logic        busy, mem_req_valid, key_valid;
  logic        mem_req_ready = 1'b0;
  logic [28:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0, key_data;
  logic [31:0] key_ptr;

  always #2 clk = ~clk;

  kf_key_fetch #(.CW(CW), .SW(SW), .DEPTH(DEPTH)) dut (.*);

  int nchk = 0, nfail = 0;
  bit done = 0;
  int cyc = 0, ready_mode = 0, rsp_hold = 0;
  logic [28:0] qaddr [0:1023];
  int qdue [0:1023];
  int qh = 0, qt = 0;
  logic [28:0] reqlog [0:1023];
  int nreq = 0;
  logic [63:0] keys [0:1023];
  logic [31:0] ptrs [0:1023];
  int nkeys = 0, stall_bad = 0, order_bad = 0;

  function automatic logic [7:0] mb(logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [63:0] word_data(logic [28:0] w);
    logic [63:0] d;
    for (int i = 0; i < 8; i++) d[8*i +: 8] = mb({w, 3'(i)});
    return d;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model and output monitor, all on the falling edge
  initial begin
    bit pv = 0, pr = 0, rsp_was;
    logic [28:0] pa = '0;
    forever begin
      @(negedge clk);
      cyc++;
      rsp_was = mem_rsp_valid;
      if (key_valid) begin
        keys[nkeys] = key_data; ptrs[nkeys] = key_ptr; nkeys++;
        if (!rsp_was) order_bad++;
      end
      if (pv && !pr && (!mem_req_valid || mem_req_addr != pa)) stall_bad++;
      mem_req_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
      pv = mem_req_valid; pr = mem_req_ready; pa = mem_req_addr;
      if (mem_req_valid && mem_req_ready) begin
        qaddr[qt % 1024] = mem_req_addr; qdue[qt % 1024] = cyc + LAT; qt++;
        reqlog[nreq % 1024] = mem_req_addr; nreq++;
      end
      if (rsp_hold == 0 && qh != qt && qdue[qh % 1024] <= cyc) begin
        mem_rsp_valid = 1'b1; mem_rsp_data = word_data(qaddr[qh % 1024]); qh++;
      end else begin
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic clear_logs();
    nreq = 0; nkeys = 0; stall_bad = 0; order_bad = 0;
  endtask

  task automatic set_cfg(logic [31:0] base, int cnt, int size, int off, int len);
    cfg_base = base; cfg_count = 16'(cnt); cfg_tuple_bytes = 16'(size);
    cfg_key_off = 16'(off); cfg_key_len = 4'(len);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_keys(int cnt);
    for (int k = 0; k < 4000 && nkeys < cnt; k++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic verify(string name, logic [31:0] base, int cnt, int size, int off, int len);
    int ri, rbad, nsplit;
    logic [31:0] p, a;
    logic [63:0] ek;
    rbad = 0; ri = 0; nsplit = 0;
    chk(nkeys == cnt, "R10", {name, " key count"}, nkeys, cnt);
    for (int t = 0; t < cnt && t < nkeys; t++) begin
      p = base + 32'(t * size);
      a = p + 32'(off);
      ek = '0;
      for (int b = 0; b < len; b++) ek[8*b +: 8] = mb(a + 32'(b));
      chk(ptrs[t] == p, "R3", {name, " pointer"}, ptrs[t], p);
      if (32'(a[2:0]) + 32'(len) > 8) begin
        nsplit++;
        chk(keys[t] == ek, "R5", {name, " straddled key"}, keys[t], ek);
      end else begin
        chk(keys[t] == ek, "R4", {name, " single-word key"}, keys[t], ek);
      end
      if (reqlog[ri] != a[31:3]) rbad++;
      ri++;
      if (32'(a[2:0]) + 32'(len) > 8) begin
        if (reqlog[ri] != a[31:3] + 29'd1) rbad++;
        ri++;
      end
    end
    chk(nreq == ri, "R4", {name, " request count"}, nreq, ri);
    chk(rbad == 0, "R3", {name, " request addresses"}, rbad, 0);
    if (len < 8) chk((keys[0] >> (8*len)) == 0, "R6", {name, " upper bytes"}, keys[0] >> (8*len), 0);
    chk(stall_bad == 0, "R7", {name, " stalled request moved"}, stall_bad, 0);
    chk(order_bad == 0, "R10", {name, " key timing"}, order_bad, 0);
  endtask

  task automatic run_case(string name, logic [31:0] base, int cnt, int size, int off, int len, int rmode);
    clear_logs();
    ready_mode = rmode;
    set_cfg(base, cnt, size, off, len);
    pulse_start();
    chk(busy == 1'b1, "R2", {name, " busy after start"}, busy, 1);
    wait_keys(cnt);
    verify(name, base, cnt, size, off, len);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(mem_req_valid == 0, "R1", "req in reset", mem_req_valid, 0);
    chk(key_valid == 0, "R1", "key in reset", key_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(mem_req_valid == 0, "R1", "req after reset", mem_req_valid, 0);
  endtask

  task automatic t_empty();
    clear_logs();
    set_cfg(32'h200, 0, 8, 0, 4);
    pulse_start();
    repeat (20) @(negedge clk);
    chk(nreq == 0, "R2", "zero count requests", nreq, 0);
    chk(busy == 0, "R2", "zero count busy", busy, 0);
  endtask

  task automatic t_depth();
    clear_logs();
    ready_mode = 0; rsp_hold = 1;
    set_cfg(32'h4000, 30, 8, 0, 4);
    pulse_start();
    repeat (40) @(negedge clk);
    chk(nreq == DEPTH, "R8", "issue with responses withheld", nreq, DEPTH);
    rsp_hold = 0;
    wait_keys(30);
    verify("depth", 32'h4000, 30, 8, 0, 4);
  endtask

  task automatic t_restart();
    clear_logs();
    ready_mode = 0;
    set_cfg(32'h800, 12, 10, 5, 6);
    pulse_start();
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R9", "busy before second start", busy, 1);
    set_cfg(32'h9000, 3, 4, 0, 2);
    pulse_start();
    set_cfg(32'h800, 12, 10, 5, 6);
    wait_keys(12);
    verify("restart R9", 32'h800, 12, 10, 5, 6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    t_reset();
    run_case("aligned", 32'h100, 6, 16, 0, 8, 0);
    run_case("lane shift", 32'h1003, 10, 12, 3, 4, 0);
    run_case("lane7 len1", 32'h2007, 5, 8, 0, 1, 0);
    run_case("full straddle", 32'h3000, 7, 24, 1, 8, 0);
    run_case("odd size stall", 32'h5001, 16, 5, 2, 3, 1);
    run_case("split stall", 32'h6006, 9, 9, 0, 7, 1);
    t_empty();
    t_depth();
    t_restart();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule